// File: doc/BRIEF.md
# Multi-Ring Transmit Halt and Event Status

This block keeps per-ring transmit status for a descriptor-driven transmit DMA that serves eight rings. Each ring has a halt flag and a frame-sent event flag. The DMA engine reports three kinds of pulse to the block:

- a frame finished on a given ring;
- the result of a descriptor fetch, carrying the ring number, the fetched ready bit, the fetched length and two error indications;
- a per-ring data-side error.

The block validates each fetched descriptor itself and latches a halt for any ring that hits an error condition or has no ready descriptor.

A halted ring has its DMA enable removed until software writes a one to the halt flag. A global graceful-stop input removes every enable while it is held. It never creates a halt. Software reaches the flags through a small register port. Status bits are write-one-to-clear, and a mask register selects which status bits drive a registered interrupt summary.

Top module: `tx_ring_status`

## Requirements
- R1: A one in bit N of `frameDone` sets the frame-event flag of ring N at that clock edge. Several rings may be set in the same cycle, and each is set independently.
- R2: A descriptor fetch result (`fetchValid`=1) with `fetchReady`=0 means the ring has no ready descriptor. It sets the halt flag of ring `fetchRing`.
- R3: A fetch result with `fetchReady`=1 and `fetchLen`=0 sets the halt flag of ring `fetchRing`. A fetch result with `fetchReady`=1, a nonzero length and no error flag changes no status bit.
- R4: The halt flag of ring N is set by any of these, whatever the value of `queueEn[N]`:
  - a fetch result for ring N with `fetchAddrErr` or `fetchReadErr` set;
  - a one in bit N of `dataErr`.
- R5: `gracefulStop` sets no halt flag. The output `dmaEnable[N]` equals `queueEn[N]` AND NOT halt[N] AND NOT `gracefulStop`.
- R6: A write to address 0 clears each status bit written with a one. Bits written with zero keep their value.
- R7: When a hardware set and a write-one-clear hit the same bit in the same cycle, the bit ends up set.
- R8: The mask register at address 1 uses the same bit layout as the status register. `irq` is a register that is loaded each cycle with the OR of (status AND mask), so `irq` follows a status change one cycle later.
- R9: Reads of address 0 return the halt flags in bits 7..0 and the event flags in bits 23..16. Reads of address 1 return the mask in the same layout. Every other bit, and every other address, reads as zero.
- R10: After reset the status and mask registers are zero and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameDone | input | 8 | Per-ring frame-sent pulse |
| fetchValid | input | 1 | Descriptor fetch result is present this cycle |
| fetchRing | input | 3 | Ring that the fetch result belongs to |
| fetchReady | input | 1 | Ready bit of the fetched descriptor |
| fetchLen | input | 16 | Length field of the fetched descriptor |
| fetchAddrErr | input | 1 | Descriptor address was invalid |
| fetchReadErr | input | 1 | Uncorrectable error on the descriptor read |
| dataErr | input | 8 | Per-ring data address or data read error pulse |
| queueEn | input | 8 | Per-ring queue enable |
| gracefulStop | input | 1 | Global graceful transmit stop |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 status, 1 mask) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| dmaEnable | output | 8 | Per-ring DMA enable |
| irq | output | 1 | Registered masked status summary |

## Verification
A status bit that is wrongly set or wrongly cleared shows up on `regRdData` in the cycle after the edge that caused it. The same error appears on `dmaEnable` at once for a halt bit, and on `irq` one edge later for a masked bit. The bench reads the whole status word after every stimulus step, so a bit that goes missing or stays stuck is seen within one cycle. It also covers the cases where a set and a clear meet in the same cycle, and the case where a write of zero must leave the flags alone.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int TXS_RINGS   = 8;
  localparam int TXS_REG_W   = 32;
  localparam int TXS_EVT_LSB = 16;
  localparam int TXS_ADDR_STATUS = 0;
  localparam int TXS_ADDR_MASK   = 1;

  // Strobes from control to datapath, one cycle's worth of updates.
  typedef struct packed {
    logic [TXS_RINGS-1:0] haltSet;
    logic [TXS_RINGS-1:0] haltClr;
    logic [TXS_RINGS-1:0] evtSet;
    logic [TXS_RINGS-1:0] evtClr;
    logic                 maskWr;
    logic [TXS_RINGS-1:0] maskHalt;
    logic [TXS_RINGS-1:0] maskEvt;
  } txs_strobe_t;
endpackage

// File: rtl/txs_ctrl.sv
module txs_ctrl
  import txs_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 2,
  localparam int RING_W = $clog2(TXS_RINGS)
) (
  input  logic [TXS_RINGS-1:0] frameDone,
  input  logic                 fetchValid,
  input  logic [RING_W-1:0]    fetchRing,
  input  logic                 fetchReady,
  input  logic [LEN_W-1:0]     fetchLen,
  input  logic                 fetchAddrErr,
  input  logic                 fetchReadErr,
  input  logic [TXS_RINGS-1:0] dataErr,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [TXS_REG_W-1:0] regWrData,
  output txs_strobe_t          strobe
);
  logic fetchBad;
  logic statusWr;
  logic maskWr;
  logic [TXS_RINGS-1:0] fetchHalt;
  logic unusedWrBits;

  // A fetched descriptor halts its ring when it is not ready (empty ring),
  // when it is ready with a zero length, or when its fetch reported an error.
  always_comb begin
    fetchBad = fetchValid &
               (~fetchReady | (fetchLen == '0) | fetchAddrErr | fetchReadErr);
    fetchHalt = fetchBad ? (TXS_RINGS'(1) << fetchRing) : '0;
  end

  assign statusWr = regWrEn && (regAddr == ADDR_W'(TXS_ADDR_STATUS));
  assign maskWr   = regWrEn && (regAddr == ADDR_W'(TXS_ADDR_MASK));

  always_comb begin
    strobe.haltSet  = fetchHalt | dataErr;
    strobe.evtSet   = frameDone;
    strobe.haltClr  = statusWr ? regWrData[TXS_RINGS-1:0] : '0;
    strobe.evtClr   = statusWr ? regWrData[TXS_EVT_LSB +: TXS_RINGS] : '0;
    strobe.maskWr   = maskWr;
    strobe.maskHalt = regWrData[TXS_RINGS-1:0];
    strobe.maskEvt  = regWrData[TXS_EVT_LSB +: TXS_RINGS];
  end

  // Write-data bits outside the two fields carry no meaning.
  assign unusedWrBits = ^regWrData;
endmodule

// File: rtl/txs_datapath.sv
module txs_datapath
  import txs_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  txs_strobe_t          strobe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [TXS_RINGS-1:0] queueEn,
  input  logic                 gracefulStop,
  output logic [TXS_REG_W-1:0] regRdData,
  output logic [TXS_RINGS-1:0] dmaEnable,
  output logic                 irq,
  output logic [TXS_RINGS-1:0] haltQ,
  output logic [TXS_RINGS-1:0] evtQ,
  output logic [TXS_RINGS-1:0] maskHaltQ,
  output logic [TXS_RINGS-1:0] maskEvtQ
);
  logic irqQ;

  // Per-ring status flops: a set in the same cycle overrides the clear.
  for (genvar r = 0; r < TXS_RINGS; r++) begin : g_ring
    logic haltBit;
    logic evtBit;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        haltBit <= 1'b0;
        evtBit  <= 1'b0;
      end else begin
        haltBit <= (haltBit & ~strobe.haltClr[r]) | strobe.haltSet[r];
        evtBit  <= (evtBit  & ~strobe.evtClr[r])  | strobe.evtSet[r];
      end
    end
    assign haltQ[r] = haltBit;
    assign evtQ[r]  = evtBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskHaltQ <= '0;
      maskEvtQ  <= '0;
    end else if (strobe.maskWr) begin
      maskHaltQ <= strobe.maskHalt;
      maskEvtQ  <= strobe.maskEvt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |({haltQ, evtQ} & {maskHaltQ, maskEvtQ});
  end
  assign irq = irqQ;

  assign dmaEnable = queueEn & ~haltQ & {TXS_RINGS{~gracefulStop}};

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(TXS_ADDR_STATUS)) begin
      regRdData[TXS_RINGS-1:0]            = haltQ;
      regRdData[TXS_EVT_LSB +: TXS_RINGS] = evtQ;
    end else if (regAddr == ADDR_W'(TXS_ADDR_MASK)) begin
      regRdData[TXS_RINGS-1:0]            = maskHaltQ;
      regRdData[TXS_EVT_LSB +: TXS_RINGS] = maskEvtQ;
    end
  end
endmodule

// File: rtl/tx_ring_status.sv
module tx_ring_status
  import txs_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 2,
  localparam int RING_W = $clog2(TXS_RINGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [TXS_RINGS-1:0] frameDone,
  input  logic                 fetchValid,
  input  logic [RING_W-1:0]    fetchRing,
  input  logic                 fetchReady,
  input  logic [LEN_W-1:0]     fetchLen,
  input  logic                 fetchAddrErr,
  input  logic                 fetchReadErr,
  input  logic [TXS_RINGS-1:0] dataErr,
  input  logic [TXS_RINGS-1:0] queueEn,
  input  logic                 gracefulStop,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [TXS_REG_W-1:0] regWrData,
  output logic [TXS_REG_W-1:0] regRdData,
  output logic [TXS_RINGS-1:0] dmaEnable,
  output logic                 irq
);
  txs_strobe_t          strobe;
  logic [TXS_RINGS-1:0] haltQ;
  logic [TXS_RINGS-1:0] evtQ;
  logic [TXS_RINGS-1:0] maskHaltQ;
  logic [TXS_RINGS-1:0] maskEvtQ;

  txs_ctrl #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_ctrl (
    .frameDone   (frameDone),
    .fetchValid  (fetchValid),
    .fetchRing   (fetchRing),
    .fetchReady  (fetchReady),
    .fetchLen    (fetchLen),
    .fetchAddrErr(fetchAddrErr),
    .fetchReadErr(fetchReadErr),
    .dataErr     (dataErr),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .strobe      (strobe)
  );

  txs_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .regAddr     (regAddr),
    .queueEn     (queueEn),
    .gracefulStop(gracefulStop),
    .regRdData   (regRdData),
    .dmaEnable   (dmaEnable),
    .irq         (irq),
    .haltQ       (haltQ),
    .evtQ        (evtQ),
    .maskHaltQ   (maskHaltQ),
    .maskEvtQ    (maskEvtQ)
  );
endmodule

// File: rtl/txs_checker.sv
module txs_checker
  import txs_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [TXS_RINGS-1:0] frameDone,
  input logic                 fetchValid,
  input logic [TXS_RINGS-1:0] dataErr,
  input logic                 gracefulStop,
  input logic                 regWrEn,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [TXS_REG_W-1:0] regWrData,
  input logic [TXS_REG_W-1:0] regRdData,
  input logic [TXS_RINGS-1:0] dmaEnable,
  input logic                 irq,
  input logic [TXS_RINGS-1:0] haltQ,
  input logic [TXS_RINGS-1:0] evtQ,
  input logic [TXS_RINGS-1:0] maskHaltQ,
  input logic [TXS_RINGS-1:0] maskEvtQ
);
  AST_HALT_BLOCKS_DMA: assert property (@(posedge clk) disable iff (!rstN)
    (haltQ & dmaEnable) == '0);  // R5

  AST_STOP_GATES_ALL: assert property (@(posedge clk) disable iff (!rstN)
    gracefulStop |-> dmaEnable == '0);  // R5

  AST_FRAME_SETS_EVT: assert property (@(posedge clk) disable iff (!rstN)
    (|frameDone) |=> ((evtQ & $past(frameDone)) == $past(frameDone)));  // R7

  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(TXS_ADDR_STATUS) &&
     regWrData[TXS_RINGS-1:0] == '0 && dataErr == '0 && !fetchValid)
    |=> haltQ == $past(haltQ));  // R6

  AST_IRQ_LAGS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irq == $past(|({haltQ, evtQ} & {maskHaltQ, maskEvtQ})));  // R8

  AST_RD_GAPS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[TXS_EVT_LSB-1:TXS_RINGS] == '0 &&
    regRdData[TXS_REG_W-1:TXS_EVT_LSB+TXS_RINGS] == '0);  // R9
endmodule

bind tx_ring_status txs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .frameDone   (frameDone),
  .fetchValid  (fetchValid),
  .dataErr     (dataErr),
  .gracefulStop(gracefulStop),
  .regWrEn     (regWrEn),
  .regAddr     (regAddr),
  .regWrData   (regWrData),
  .regRdData   (regRdData),
  .dmaEnable   (dmaEnable),
  .irq         (irq),
  .haltQ       (haltQ),
  .evtQ        (evtQ),
  .maskHaltQ   (maskHaltQ),
  .maskEvtQ    (maskEvtQ)
);

// File: tb/tx_ring_status_tb.sv
module tx_ring_status_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  frameDone = '0;
  logic        fetchValid = 1'b0;
  logic [2:0]  fetchRing = '0;
  logic        fetchReady = 1'b0;
  logic [15:0] fetchLen = '0;
  logic        fetchAddrErr = 1'b0;
  logic        fetchReadErr = 1'b0;
  logic [7:0]  dataErr = '0;
  logic [7:0]  queueEn = 8'hFF;
  logic        gracefulStop = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [7:0]  dmaEnable;
  logic        irq;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  tx_ring_status u_dut (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .fetchValid(fetchValid),
    .fetchRing(fetchRing), .fetchReady(fetchReady), .fetchLen(fetchLen),
    .fetchAddrErr(fetchAddrErr), .fetchReadErr(fetchReadErr), .dataErr(dataErr),
    .queueEn(queueEn), .gracefulStop(gracefulStop), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .dmaEnable(dmaEnable), .irq(irq)
  );

  typedef struct packed {
    logic [7:0]  frame;
    logic        fv;
    logic [2:0]  ring;
    logic        rdy;
    logic [15:0] len;
    logic        aerr;
    logic        rerr;
    logic [7:0]  derr;
    logic        gs;
    logic        wr;
    logic [1:0]  waddr;
    logic [31:0] wdata;
    logic [31:0] expSt;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{8'h05, 1'b0, 3'd0, 1'b0, 16'd0,   1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 32'h0000_0000, 32'h0005_0000},
    '{8'h00, 1'b1, 3'd3, 1'b1, 16'd0,   1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 32'h0000_0000, 32'h0005_0008},
    '{8'h00, 1'b1, 3'd5, 1'b0, 16'd100, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 32'h0000_0000, 32'h0005_0028},
    '{8'h00, 1'b1, 3'd1, 1'b1, 16'd64,  1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 32'h0000_0000, 32'h0005_0028},
    '{8'h00, 1'b1, 3'd6, 1'b1, 16'd10,  1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 32'h0000_0000, 32'h0005_0068},
    '{8'h00, 1'b1, 3'd0, 1'b1, 16'd20,  1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 2'd0, 32'h0000_0000, 32'h0005_0069},
    '{8'h00, 1'b0, 3'd0, 1'b0, 16'd0,   1'b0, 1'b0, 8'h80, 1'b0, 1'b0, 2'd0, 32'h0000_0000, 32'h0005_00E9},
    '{8'h00, 1'b0, 3'd0, 1'b0, 16'd0,   1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 2'd0, 32'h0000_0000, 32'h0005_00E9},
    '{8'h00, 1'b0, 3'd0, 1'b0, 16'd0,   1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 2'd0, 32'h0001_0008, 32'h0004_00E1},
    '{8'h04, 1'b0, 3'd0, 1'b0, 16'd0,   1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 2'd0, 32'hFFFF_FFFF, 32'h0004_0000},
    '{8'h02, 1'b0, 3'd0, 1'b0, 16'd0,   1'b0, 1'b0, 8'h02, 1'b0, 1'b1, 2'd0, 32'h0004_0000, 32'h0002_0002},
    '{8'h00, 1'b0, 3'd0, 1'b0, 16'd0,   1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 32'h0000_0000, 32'h0002_0002}
  };

  function automatic string tagOf(input int idx);
    case (idx)
      0:       return "R1 multi-ring frame events";
      1:       return "R3 ready with zero length";
      2:       return "R2 empty ring";
      3:       return "R3 good descriptor no effect";
      4:       return "R4 descriptor address error";
      5:       return "R4 descriptor read error";
      6:       return "R4 data error";
      7:       return "R6 write of zero";
      8:       return "R6 write-one-clear";
      9:       return "R7 set beats clear event";
      10:      return "R7 mixed set and clear";
      default: return "R5 graceful stop no halt";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idleInputs();
    frameDone = '0; fetchValid = 1'b0; fetchReady = 1'b0; fetchLen = '0;
    fetchAddrErr = 1'b0; fetchReadErr = 1'b0; dataErr = '0;
    gracefulStop = 1'b0; regWrEn = 1'b0; regWrData = '0; regAddr = 2'd0;
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    chk("R10 status after reset", regRdData, 32'h0);
    regAddr = 2'd1;
    #1 chk("R10 mask after reset", regRdData, 32'h0);
    chk("R10 irq after reset", {31'b0, irq}, 32'h0);
    chk("R5 enable after reset", {24'b0, dmaEnable}, 32'h0000_00FF);
    regAddr = 2'd0;
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      frameDone = VECS[i].frame; fetchValid = VECS[i].fv; fetchRing = VECS[i].ring;
      fetchReady = VECS[i].rdy; fetchLen = VECS[i].len; fetchAddrErr = VECS[i].aerr;
      fetchReadErr = VECS[i].rerr; dataErr = VECS[i].derr; gracefulStop = VECS[i].gs;
      regWrEn = VECS[i].wr; regAddr = VECS[i].waddr; regWrData = VECS[i].wdata;
      @(negedge clk);
      idleInputs();
      #1 chk(tagOf(i), regRdData, VECS[i].expSt);
    end

    // Status now: halt1, event1 set.
    chk("R5 halted ring gated", {24'b0, dmaEnable}, 32'h0000_00FD);
    gracefulStop = 1'b1;
    #1 chk("R5 graceful stop gates all", {24'b0, dmaEnable}, 32'h0);
    gracefulStop = 1'b0;

    // R4: halt set while the ring's queue enable is off.
    queueEn = 8'h00;
    dataErr = 8'h10;
    @(negedge clk);
    dataErr = '0;
    #1 chk("R4 halt ignores queue enable", regRdData, 32'h0002_0012);
    chk("R5 no enable when queues off", {24'b0, dmaEnable}, 32'h0);
    queueEn = 8'hFF;

    // R9: mask bits outside the fields are dropped.
    regWrEn = 1'b1; regAddr = 2'd1; regWrData = 32'hFF00_FF00;
    @(negedge clk);
    regWrEn = 1'b0;
    #1 chk("R9 mask gaps read zero", regRdData, 32'h0);
    regWrEn = 1'b1; regWrData = 32'h0000_0001;
    @(negedge clk);
    regWrEn = 1'b0;
    #1 chk("R9 mask readback", regRdData, 32'h0000_0001);
    regAddr = 2'd2;
    #1 chk("R9 unmapped address", regRdData, 32'h0);
    regAddr = 2'd0;
    @(negedge clk);
    chk("R8 unmasked bits give no irq", {31'b0, irq}, 32'h0);

    // R8: irq follows a masked status bit one cycle later.
    dataErr = 8'h01;
    @(negedge clk);
    dataErr = '0;
    #1 chk("R8 status bit set", regRdData, 32'h0002_0013);
    chk("R8 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq one cycle later", {31'b0, irq}, 32'h1);

    regWrEn = 1'b1; regAddr = 2'd0; regWrData = 32'h0000_0001;
    @(negedge clk);
    idleInputs();
    #1 chk("R6 clear masked halt", regRdData, 32'h0002_0012);
    chk("R8 irq holds for one cycle", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R8 irq drops", {31'b0, irq}, 32'h0);

    finishRun();
  end
endmodule